// File: doc/BRIEF.md
# Flow-Gated Serial Transmitter

This block serializes bytes onto an asynchronous serial line in a fixed 8N1 frame, with each bit timed by a sixteen-times baud enable. Bytes come in over a valid/ready handshake. The block takes a byte only while it is idle and the far end allows transmission.

The far end signals permission on an active-low clear-to-send input. When automatic gating is enabled and that input goes high, the current character still goes out in full, through its stop bit. The next start bit is held back until the input returns low. A high-going transition of the clear-to-send input can set a sticky status flag and raise an interrupt. Reading the status clears the flag.

Top module: `cts_uart_tx`

## Requirements
- R1: The line idles high. A frame is one low start bit, then the 8 data bits with bit 0 first, then one high stop bit.
- R2: Every bit lasts exactly 16 baud-enable pulses. The line does not change on a cycle without a pulse. From the accepting clock edge to the fall of `busy` there are between 159*P+1 and 160*P clock cycles, where P is the pulse period in clocks.
- R3: A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `busy` is high from that edge until the end of the stop bit. `in_ready` is low whenever `busy` is high.
- R4: With `flow_en` low, the clear-to-send input has no effect on transmission.
- R5: If clear-to-send is deasserted (high) during a frame, that frame completes unchanged through its stop bit.
- R6: With `flow_en` high and clear-to-send synchronized high, `in_ready` stays low, `busy` stays low and the line stays high.
- R7: After clear-to-send returns low, `in_ready` rises within 4 clocks. The next byte then goes out normally.
- R8: With `irq_en` high, a low-to-high transition of clear-to-send sets `cts_stat` and drives `irq` high within 4 clocks.
- R9: A one-cycle `status_rd` clears `cts_stat`. The flag stays clear while clear-to-send is held high, and a new high-going transition sets it again.
- R10: With `irq_en` low, a high-going transition of clear-to-send sets neither `cts_stat` nor `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Baud enable at 16 times the bit rate |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Byte can be taken this cycle |
| cts_n | input | 1 | Active-low clear-to-send, asynchronous |
| flow_en | input | 1 | Enables gating by clear-to-send |
| irq_en | input | 1 | Enables the clear-to-send interrupt |
| status_rd | input | 1 | Status read strobe, clears the flag |
| tx | output | 1 | Serial output |
| busy | output | 1 | Frame in progress |
| irq | output | 1 | Interrupt request |
| cts_stat | output | 1 | Sticky clear-to-send change flag |

## Verification
A wrong state or bit-index register shows up at once at `tx`. A start bit in the wrong place, a byte with its bits swapped or a missing stop bit appears within one bit time, and a wrong timing counter shifts the fall of `busy` by at least one baud pulse. A bad gating decision shows up as a start bit on the line or a raised `in_ready` while clear-to-send is high. It can also show up as a frame cut short when clear-to-send rises mid-character. A fault in the flag path shows at `cts_stat` within a few clocks of an edge or read strobe.

// File: rtl/cts_tx_pkg.sv
`timescale 1ns/1ps
package cts_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/cts_tx_sync.sv
`timescale 1ns/1ps
module cts_tx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n_async,
  output logic cts_n_sync,
  output logic cts_rise
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              last_q;

  always_comb begin
    chain_d    = chain_q << 1;
    chain_d[0] = cts_n_async;
  end

  // reset to "deasserted" so release from reset is not seen as an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      last_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign cts_n_sync = chain_q[STAGES-1];
  assign cts_rise   = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/cts_tx_serializer.sv
`timescale 1ns/1ps
module cts_tx_serializer
  import cts_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold,
  input  logic              ld_valid,
  input  logic [DATA_W-1:0] ld_data,
  output logic              ld_ready,
  output logic              tx,
  output logic              busy
);
  localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  tx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              bit_end;

  assign bit_end = tick && (cnt_q == CNT_LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    if (state_q == ST_IDLE) begin
      // gating decision taken only here, before a start bit is launched
      if (ld_valid && !hold) begin
        sh_d    = ld_data;
        cnt_d   = '0;
        idx_d   = '0;
        state_d = ST_START;
      end
    end else if (tick) begin
      cnt_d = bit_end ? '0 : cnt_q + 1'b1;
      if (bit_end) begin
        unique case (state_q)
          ST_START: state_d = ST_DATA;
          ST_DATA: begin
            sh_d = sh_q >> 1;
            if (idx_q == IDX_LAST) begin
              state_d = ST_STOP;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end
          ST_STOP: state_d = ST_IDLE;
          default: state_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: tx = 1'b0;
      ST_DATA:  tx = sh_q[0];
      default:  tx = 1'b1;
    endcase
  end

  assign busy     = (state_q != ST_IDLE);
  assign ld_ready = (state_q == ST_IDLE) && !hold;
endmodule

// File: rtl/cts_tx_irq.sv
`timescale 1ns/1ps
module cts_tx_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_rise,
  input  logic irq_en,
  input  logic clr,
  output logic flag
);
  logic flag_q, flag_d;

  // a new edge wins over a read in the same cycle, so no event is lost
  always_comb begin
    flag_d = flag_q;
    if (cts_rise && irq_en) begin
      flag_d = 1'b1;
    end else if (clr) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/cts_uart_tx.sv
`timescale 1ns/1ps
module cts_uart_tx #(
  parameter int DATA_W      = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              cts_n,
  input  logic              flow_en,
  input  logic              irq_en,
  input  logic              status_rd,
  output logic              tx,
  output logic              busy,
  output logic              irq,
  output logic              cts_stat
);
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  logic       cts_n_sync;
  logic       cts_rise;
  logic       hold;
  logic       cts_flag;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe_q[1];

  cts_tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .cts_n_async (cts_n),
    .cts_n_sync  (cts_n_sync),
    .cts_rise    (cts_rise)
  );

  assign hold = flow_en && cts_n_sync;

  cts_tx_serializer #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_ser (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .tick     (tick16),
    .hold     (hold),
    .ld_valid (in_valid),
    .ld_data  (in_data),
    .ld_ready (in_ready),
    .tx       (tx),
    .busy     (busy)
  );

  cts_tx_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .cts_rise (cts_rise),
    .irq_en   (irq_en),
    .clr      (status_rd),
    .flag     (cts_flag)
  );

  assign cts_stat = cts_flag;
  assign irq      = cts_flag && irq_en;
endmodule

// File: rtl/cts_uart_tx_checker.sv
`timescale 1ns/1ps
module cts_uart_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic in_valid,
  input logic in_ready,
  input logic tx,
  input logic busy,
  input logic irq_en,
  input logic status_rd,
  input logic cts_rise,
  input logic cts_flag
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx);

  assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick16) |=> $stable(tx));

  assert_start_on_handshake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid && in_ready));

  assert_no_ready_when_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  assert_frame_ends_on_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tx));

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !cts_rise) |=> !cts_flag);

  assert_flag_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cts_flag) |-> $past(irq_en && cts_rise));
endmodule

bind cts_uart_tx cts_uart_tx_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .tick16    (tick16),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .tx        (tx),
  .busy      (busy),
  .irq_en    (irq_en),
  .status_rd (status_rd),
  .cts_rise  (cts_rise),
  .cts_flag  (cts_flag)
);

// File: tb/cts_uart_tx_bench.sv
`timescale 1ns/1ps
module cts_uart_tx_bench;
  logic       clk;
  logic       rst_n;
  logic       tick16;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_ready;
  logic       cts_n;
  logic       flow_en;
  logic       irq_en;
  logic       status_rd;
  logic       tx;
  logic       busy;
  logic       irq;
  logic       cts_stat;

  int checks;
  int errors;
  int tick_per;
  int tick_cnt;
  int last_wait;
  bit done;

  cts_uart_tx u_cts_uart_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick16    (tick16),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .cts_n     (cts_n),
    .flow_en   (flow_en),
    .irq_en    (irq_en),
    .status_rd (status_rd),
    .tx        (tx),
    .busy      (busy),
    .irq       (irq),
    .cts_stat  (cts_stat)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // baud enable: one pulse every tick_per clocks
  always @(posedge clk) begin
    if (tick_cnt + 1 >= tick_per) tick_cnt <= 0;
    else tick_cnt <= tick_cnt + 1;
  end
  assign tick16 = (tick_cnt == 0);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // offer a byte, then follow the frame on tx and check it
  task automatic xfer(input logic [7:0] b, input int raise_at, input string req);
    int n;
    int waitc;
    logic [9:0] got;
    bit rdy_ok;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    waitc = 0;
    while (!in_ready) begin
      @(negedge clk);
      waitc++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    last_wait = waitc;
    n = 0;
    got = '0;
    rdy_ok = 1'b1;
    while (busy && n < 200 * tick_per) begin
      if (n == raise_at) cts_n = 1'b1;
      if (n >= 8 * tick_per && ((n - 8 * tick_per) % (16 * tick_per)) == 0
          && ((n - 8 * tick_per) / (16 * tick_per)) < 10)
        got[(n - 8 * tick_per) / (16 * tick_per)] = tx;
      if (in_ready) rdy_ok = 1'b0;
      @(negedge clk);
      n++;
    end
    chk(got == {1'b1, b, 1'b0}, {req, " R1 frame"}, int'(got), int'({1'b1, b, 1'b0}));
    chk(n >= 159 * tick_per + 1 && n <= 160 * tick_per, {req, " R2 length"}, n, 160 * tick_per);
    chk(rdy_ok, {req, " R3 ready low while busy"}, 0, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end

  initial begin
    bit ok;
    checks = 0; errors = 0; done = 0;
    tick_per = 1; tick_cnt = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    cts_n = 1'b0; flow_en = 1'b0; irq_en = 1'b0; status_rd = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx === 1'b1 && busy === 1'b0, "R1 reset idle", int'(tx), 1);
    chk(cts_stat === 1'b0 && irq === 1'b0, "R8 reset flag clear", int'(cts_stat), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(in_ready === 1'b1, "R3 ready after reset", int'(in_ready), 1);

    // R1 R2: every byte value at one pulse per clock
    for (int v = 0; v < 256; v++) xfer(8'(v), -1, "sweep P1");

    // R2: slower baud enable
    tick_per = 3;
    for (int v = 0; v < 16; v++) xfer(8'((v * 37) ^ 8'h5A), -1, "sweep P3");
    tick_per = 1;

    // R4: gating disabled, clear-to-send high ignored
    cts_n = 1'b1;
    repeat (5) @(negedge clk);
    xfer(8'hC3, -1, "R4 ungated");
    chk(last_wait == 0, "R4 no wait", last_wait, 0);
    cts_n = 1'b0;
    repeat (5) @(negedge clk);

    // R5: deassert mid-frame, frame still completes
    flow_en = 1'b1; irq_en = 1'b1;
    repeat (5) @(negedge clk);
    xfer(8'hA5, 40, "R5 mid-frame");

    // R8: flag and interrupt raised by the edge
    chk(cts_stat === 1'b1 && irq === 1'b1, "R8 flag set", int'(cts_stat), 1);

    // R6: gated idle, byte offered but nothing starts
    @(negedge clk); in_valid = 1'b1; in_data = 8'h3C;
    ok = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (in_ready !== 1'b0 || busy !== 1'b0 || tx !== 1'b1) ok = 1'b0;
    end
    chk(ok, "R6 held off", int'(busy), 0);

    // R9: read clears, stays clear while held high
    status_rd = 1'b1; @(negedge clk); status_rd = 1'b0;
    chk(cts_stat === 1'b0, "R9 cleared", int'(cts_stat), 0);
    repeat (50) @(negedge clk);
    chk(cts_stat === 1'b0 && irq === 1'b0, "R9 stays clear", int'(cts_stat), 0);

    // R7: release, waiting byte goes out promptly
    cts_n = 1'b0;
    xfer(8'h3C, -1, "R7 resume");
    chk(last_wait <= 4, "R7 resume latency", last_wait, 4);

    // R9: a new edge sets the flag again
    cts_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(cts_stat === 1'b1, "R9 new edge sets", int'(cts_stat), 1);
    status_rd = 1'b1; @(negedge clk); status_rd = 1'b0;
    cts_n = 1'b0;
    repeat (5) @(negedge clk);

    // R10: interrupt disabled, edge ignored
    irq_en = 1'b0;
    cts_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(cts_stat === 1'b0 && irq === 1'b0, "R10 no flag", int'(cts_stat), 0);
    cts_n = 1'b0;
    repeat (5) @(negedge clk);
    xfer(8'h81, -1, "R7 after R10");

    done = 1;
    summary();
  end
endmodule